// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder with Carry Terminals

This block adds two unsigned N-bit operands and an incoming carry. It returns an N-bit sum and the carry leaving the top bit. Each bit position first forms a propagate and a generate term. A parallel-prefix network then combines these terms into group generates, so every position learns in logarithmic depth whether a carry reaches it. The sum bits are the per-bit propagates XORed with the group generate of the bits below.

The incoming carry is merged into bit 0 with a full-adder cell. The prefix network therefore keeps the same shape and depth whether or not a carry input is present. A parameter selects one of three network shapes: sparse up/down sweep (Brent-Kung), dense doubling (Kogge-Stone) or odd-position doubling with a final even fix-up (Han-Carlson). The shapes differ only in area and wiring, not in result. Optional register stages at the inputs and at the outputs set the latency to 0, 1 or 2 cycles.

Top module: `ppa_adder`

## Requirements
- R1: With carry-in and carry-out enabled, {cout, o} equals a + b + cin, taken modulo 2^(WIDTH+1), for every operand value.
- R2: All three network shapes produce identical outputs for identical inputs. TOPOLOGY selects the shape: 0 is sparse up/down sweep, 1 is dense doubling and 2 is odd-position doubling.
- R3: Sum bit 0 equals a[0] XOR b[0] XOR cin and does not depend on any higher operand bit.
- R4: With USE_CIN = 0, the cin port has no effect and o equals a + b truncated to WIDTH bits.
- R5: With USE_COUT = 0, cout is held at 0 for every input.
- R6: Results appear REG_IN + REG_OUT clock cycles after the inputs are presented, and o and cout always belong to the same input set.
- R7: While rst_n is low, every enabled register is cleared, and o and cout read 0 whatever the inputs are.
- R8: A carry travels the full width. All-ones plus zero plus carry-in gives o = 0 and cout = 1. All-ones plus all-ones plus carry-in gives o = all-ones and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Asynchronous active-low reset for the register stages |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Incoming carry at bit 0 (ignored when USE_CIN = 0) |
| o | output | WIDTH | Sum |
| cout | output | 1 | Carry out of the top bit (0 when USE_COUT = 0) |

## Verification
A wrong group-generate term in the prefix network corrupts the sum bit directly above its span. It also corrupts every higher sum bit and cout whose carry depends on that span. The error shows at the ports in the same cycle the inputs are applied, or REG_IN + REG_OUT cycles later. Such an error appears only for operand patterns that generate or propagate a carry across that span, so exhaustive sweeps at widths 5 and 8 reach every network node. Width 5 is not a power of two, which exposes missing nodes in the sparse and odd-position shapes. A register on the wrong side of the latency count shows up as a result that is offset by one input set in the streamed runs.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

   // Prefix network shapes selectable through the TOPOLOGY parameter.
   localparam int TOPO_SPARSE = 0;  // up-sweep / down-sweep (Brent-Kung)
   localparam int TOPO_DENSE  = 1;  // full doubling (Kogge-Stone)
   localparam int TOPO_ODD    = 2;  // doubling on odd bits plus fix-up (Han-Carlson)

   // Combine a higher {G,P} pair with the adjacent lower one.
   function automatic logic [1:0] pfx_op(input logic [1:0] hi, input logic [1:0] lo);
      return {hi[1] | (hi[0] & lo[1]), hi[0] & lo[0]};
   endfunction

endpackage

// File: rtl/ppa_pg_cells.sv
module ppa_pg_cells #(
   parameter int WIDTH   = 64,
   parameter int USE_CIN = 1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] p,
   output logic [WIDTH-1:0] g
);

   // Bit 0: full-adder cell absorbs the incoming carry, or half-adder cell.
   if (USE_CIN != 0) begin : g_lsb_full
      assign p[0] = a[0] ^ b[0] ^ cin;
      assign g[0] = (a[0] & b[0]) | (a[0] & cin) | (b[0] & cin);
   end else begin : g_lsb_half
      assign p[0] = a[0] ^ b[0];
      assign g[0] = a[0] & b[0];
   end

   // Bits 1..WIDTH-1: half-adder cells.
   for (genvar i = 1; i < WIDTH; i++) begin : g_bit
      assign p[i] = a[i] ^ b[i];
      assign g[i] = a[i] & b[i];
   end

endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree
   import ppa_pkg::*;
#(
   parameter int WIDTH    = 64,
   parameter int TOPOLOGY = TOPO_SPARSE
) (
   input  logic [WIDTH-1:0] p,
   input  logic [WIDTH-1:0] g,
   output logic [WIDTH-1:0] grp_g   // grp_g[i] = G[i:0]
);

   // Largest power of two below WIDTH: first stride of the down-sweep.
   localparam int TOP_STRIDE = 2 ** ($clog2(WIDTH) - 1);

   logic [WIDTH-1:0] gg;
   logic [WIDTH-1:0] pp;

   if (TOPOLOGY == TOPO_SPARSE) begin : g_sparse
      always_comb begin
         gg = g;
         pp = p;
         // Up-sweep: node i with (i+1) a multiple of 2d absorbs the node d below.
         for (int d = 1; d < WIDTH; d = d * 2) begin
            for (int i = WIDTH - 1; i >= d; i--) begin
               if (((i + 1) % (2 * d)) == 0)
                  {gg[i], pp[i]} = pfx_op({gg[i], pp[i]}, {gg[i-d], pp[i-d]});
            end
         end
         // Down-sweep: fill the remaining positions from completed anchors.
         for (int d = TOP_STRIDE; d >= 1; d = d / 2) begin
            for (int i = WIDTH - 1; i >= 3 * d - 1; i--) begin
               if (((i + 1) % (2 * d)) == d)
                  {gg[i], pp[i]} = pfx_op({gg[i], pp[i]}, {gg[i-d], pp[i-d]});
            end
         end
      end
   end else if (TOPOLOGY == TOPO_DENSE) begin : g_dense
      always_comb begin
         gg = g;
         pp = p;
         // Every node absorbs the node d below at every level; descending
         // order keeps the lower operand at its previous-level value.
         for (int d = 1; d < WIDTH; d = d * 2) begin
            for (int i = WIDTH - 1; i >= d; i--)
               {gg[i], pp[i]} = pfx_op({gg[i], pp[i]}, {gg[i-d], pp[i-d]});
         end
      end
   end else begin : g_odd
      always_comb begin
         gg = g;
         pp = p;
         // Doubling restricted to odd positions.
         for (int d = 1; d < WIDTH; d = d * 2) begin
            for (int i = WIDTH - 1; i >= d; i--) begin
               if ((i % 2) == 1)
                  {gg[i], pp[i]} = pfx_op({gg[i], pp[i]}, {gg[i-d], pp[i-d]});
            end
         end
         // Final level: each even position takes its odd neighbour below.
         for (int i = 2; i < WIDTH; i += 2)
            {gg[i], pp[i]} = pfx_op({gg[i], pp[i]}, {gg[i-1], pp[i-1]});
      end
   end

   assign grp_g = gg;

endmodule

// File: rtl/ppa_sum.sv
module ppa_sum #(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] p,      // untouched per-bit propagates
   input  logic [WIDTH-1:0] grp_g,
   output logic [WIDTH-1:0] s
);

   assign s[0] = p[0];
   for (genvar i = 1; i < WIDTH; i++) begin : g_xor
      assign s[i] = p[i] ^ grp_g[i-1];
   end

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
   import ppa_pkg::*;
#(
   parameter int WIDTH    = 64,
   parameter int TOPOLOGY = TOPO_SPARSE,
   parameter int USE_CIN  = 1,
   parameter int USE_COUT = 1,
   parameter int REG_IN   = 0,
   parameter int REG_OUT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] o,
   output logic             cout
);

   // Elaboration-time parameter checks
   if (WIDTH < 2) begin : g_bad_width
      $error("ppa_adder: WIDTH must be at least 2");
   end
   if (TOPOLOGY < TOPO_SPARSE || TOPOLOGY > TOPO_ODD) begin : g_bad_topo
      $error("ppa_adder: TOPOLOGY must be 0, 1 or 2");
   end
   if (USE_CIN > 1 || USE_COUT > 1 || REG_IN > 1 || REG_OUT > 1 ||
       USE_CIN < 0 || USE_COUT < 0 || REG_IN < 0 || REG_OUT < 0) begin : g_bad_flag
      $error("ppa_adder: option flags must be 0 or 1");
   end

   logic [WIDTH-1:0] a_s, b_s;
   logic             cin_s;
   logic [WIDTH-1:0] p_bit, g_bit, grp_g, sum_c;
   logic             cout_c;

   // Optional input stage: all operands captured on the same edge.
   if (REG_IN != 0) begin : g_in_reg
      logic [WIDTH-1:0] a_q, b_q;
      logic             cin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
         end else begin
            a_q   <= a;
            b_q   <= b;
            cin_q <= cin;
         end
      end
      assign a_s   = a_q;
      assign b_s   = b_q;
      assign cin_s = cin_q;
   end else begin : g_in_wire
      assign a_s   = a;
      assign b_s   = b;
      assign cin_s = cin;
   end

   ppa_pg_cells #(
      .WIDTH   (WIDTH),
      .USE_CIN (USE_CIN)
   ) u_pg (
      .a   (a_s),
      .b   (b_s),
      .cin (cin_s),
      .p   (p_bit),
      .g   (g_bit)
   );

   ppa_prefix_tree #(
      .WIDTH    (WIDTH),
      .TOPOLOGY (TOPOLOGY)
   ) u_tree (
      .p     (p_bit),
      .g     (g_bit),
      .grp_g (grp_g)
   );

   ppa_sum #(
      .WIDTH (WIDTH)
   ) u_sum (
      .p     (p_bit),
      .grp_g (grp_g),
      .s     (sum_c)
   );

   // Carry out is the group generate over the full width.
   if (USE_COUT != 0) begin : g_cout
      assign cout_c = grp_g[WIDTH-1];
   end else begin : g_no_cout
      assign cout_c = 1'b0;
   end

   // Optional output stage: sum and carry share one register level.
   if (REG_OUT != 0) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            o    <= '0;
            cout <= 1'b0;
         end else begin
            o    <= sum_c;
            cout <= cout_c;
         end
      end
   end else begin : g_out_wire
      assign o    = sum_c;
      assign cout = cout_c;
   end

endmodule

// File: rtl/ppa_adder_chk.sv
module ppa_adder_chk #(
   parameter int WIDTH    = 64,
   parameter int USE_CIN  = 1,
   parameter int USE_COUT = 1,
   parameter int REG_IN   = 0,
   parameter int REG_OUT  = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             cin,
   input logic [WIDTH-1:0] o,
   input logic             cout
);

   localparam int LAT = REG_IN + REG_OUT;

   typedef struct packed {
      logic [WIDTH:0] full;
      logic [WIDTH:0] nocin;
      logic           lsb;
   } exp_t;

   exp_t       e_now, e_q1, e_q2, e_use;
   logic [1:0] age;
   logic       cin_eff;

   assign cin_eff = cin & (USE_CIN != 0);

   always_comb begin
      e_now.full  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin_eff};
      e_now.nocin = {1'b0, a} + {1'b0, b};
      e_now.lsb   = a[0] ^ b[0] ^ cin_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_q1 <= '0;
         e_q2 <= '0;
         age  <= 2'd0;
      end else begin
         e_q1 <= e_now;
         e_q2 <= e_q1;
         if (age != 2'd2) age <= age + 2'd1;
      end
   end

   assign e_use = (LAT == 0) ? e_now : ((LAT == 1) ? e_q1 : e_q2);

   AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(age) >= LAT) |-> (o == e_use.full[WIDTH-1:0]) &&
                             ((USE_COUT == 0) || (cout == e_use.full[WIDTH]))); // R1

   AST_SUM_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(age) >= LAT) |-> (o[0] == e_use.lsb)); // R3

   AST_CIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((USE_CIN == 0) && (int'(age) >= LAT)) |-> (o == e_use.nocin[WIDTH-1:0])); // R4

   AST_COUT_TIED: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_COUT == 0) |-> (cout == 1'b0)); // R5

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((LAT > 0) && !$past(rst_n)) |-> ((o == '0) && !cout)); // R7

endmodule

bind ppa_adder ppa_adder_chk #(
   .WIDTH    (WIDTH),
   .USE_CIN  (USE_CIN),
   .USE_COUT (USE_COUT),
   .REG_IN   (REG_IN),
   .REG_OUT  (REG_OUT)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .a     (a),
   .b     (b),
   .cin   (cin),
   .o     (o),
   .cout  (cout)
);

// File: tb/tb_ppa_adder.sv
module tb_ppa_adder;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   int total = 0;
   int fails = 0;

   task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Exhaustive sweep instances: width 8 and width 5, all three shapes, no registers.
   logic [7:0] ea, eb;
   logic       ecin;
   logic [7:0] o8 [3];
   logic       c8 [3];
   logic [4:0] fa, fb;
   logic       fcin;
   logic [4:0] o5 [3];
   logic       c5 [3];

   for (genvar t = 0; t < 3; t++) begin : g_sweep
      ppa_adder #(.WIDTH(8), .TOPOLOGY(t), .REG_OUT(0)) u_w8 (
         .clk(clk), .rst_n(rst_n), .a(ea), .b(eb), .cin(ecin), .o(o8[t]), .cout(c8[t]));
      ppa_adder #(.WIDTH(5), .TOPOLOGY(t), .REG_OUT(0)) u_w5 (
         .clk(clk), .rst_n(rst_n), .a(fa), .b(fb), .cin(fcin), .o(o5[t]), .cout(c5[t]));
   end

   // Streamed instances
   logic [63:0] sa, sb;
   logic        scin;
   logic [63:0] o_d, o_ks, o_hc;
   logic        c_d, c_ks, c_hc;
   logic [7:0]  o_p2, o_nc;
   logic        c_p2, c_nc;

   ppa_adder dut (   // defaults: width 64, sparse shape, output register
      .clk(clk), .rst_n(rst_n), .a(sa), .b(sb), .cin(scin), .o(o_d), .cout(c_d));
   ppa_adder #(.WIDTH(64), .TOPOLOGY(1), .REG_OUT(0)) dut_ks (
      .clk(clk), .rst_n(rst_n), .a(sa), .b(sb), .cin(scin), .o(o_ks), .cout(c_ks));
   ppa_adder #(.WIDTH(64), .TOPOLOGY(2), .REG_OUT(0)) dut_hc (
      .clk(clk), .rst_n(rst_n), .a(sa), .b(sb), .cin(scin), .o(o_hc), .cout(c_hc));
   ppa_adder #(.WIDTH(8), .TOPOLOGY(2), .REG_IN(1), .REG_OUT(1)) dut_p2 (
      .clk(clk), .rst_n(rst_n), .a(sa[7:0]), .b(sb[7:0]), .cin(scin), .o(o_p2), .cout(c_p2));
   ppa_adder #(.WIDTH(8), .TOPOLOGY(1), .USE_CIN(0), .USE_COUT(0), .REG_IN(1), .REG_OUT(0)) dut_nc (
      .clk(clk), .rst_n(rst_n), .a(sa[7:0]), .b(sb[7:0]), .cin(scin), .o(o_nc), .cout(c_nc));

   function automatic logic [64:0] ref64(input logic [63:0] x, input logic [63:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {64'd0, c};
   endfunction

   task automatic pick(input int k, output logic [63:0] va, output logic [63:0] vb, output logic vc);
      case (k)
         0: begin va = '0;                     vb = '0;                     vc = 1'b0; end
         1: begin va = '1;                     vb = '0;                     vc = 1'b1; end
         2: begin va = '1;                     vb = '1;                     vc = 1'b1; end
         3: begin va = 64'h5555_5555_5555_5555; vb = 64'hAAAA_AAAA_AAAA_AAAA; vc = 1'b1; end
         4: begin va = 64'hAAAA_AAAA_AAAA_AAAA; vb = 64'hAAAA_AAAA_AAAA_AAAA; vc = 1'b0; end
         5: begin va = 64'd1;                  vb = '1;                     vc = 1'b0; end
         6: begin va = '0;                     vb = '0;                     vc = 1'b1; end
         default: begin
            va = {$urandom(), $urandom()};
            vb = {$urandom(), $urandom()};
            vc = 1'($urandom());
         end
      endcase
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [63:0] h1a, h1b, h2a, h2b, va, vb;
      logic        h1c, h2c, vc;
      logic [8:0]  e8;
      logic [5:0]  e5;
      h1a = '0; h1b = '0; h1c = 1'b0;
      h2a = '0; h2b = '0; h2c = 1'b0;
      ea = '0; eb = '0; ecin = 1'b0;
      fa = '0; fb = '0; fcin = 1'b0;
      sa = '1; sb = '1; scin = 1'b1;

      // R7: registered outputs held at zero during reset despite nonzero inputs.
      repeat (3) @(negedge clk);
      chk("R7 dut", {c_d, o_d}, '0);
      chk("R7 dut_p2", {c_p2, o_p2}, '0);
      chk("R7 dut_nc", {c_nc, o_nc}, '0);

      // Width-8 exhaustive sweep over all shapes (R1, R2, R8 at the extremes).
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            for (int c = 0; c < 2; c++) begin
               ea = 8'(x); eb = 8'(y); ecin = 1'(c);
               #1;
               e8 = 9'(x + y + c);
               for (int t = 0; t < 3; t++)
                  chk((x == 255 && c == 1) ? "R8 w8" : "R1 w8", {c8[t], o8[t]}, e8);
               chk("R2 w8 dense vs sparse", {c8[1], o8[1]}, {c8[0], o8[0]});
               chk("R2 w8 odd vs sparse", {c8[2], o8[2]}, {c8[0], o8[0]});
            end
         end
      end

      // Width-5 exhaustive sweep: non-power-of-two width (R1, R2, R3).
      for (int x = 0; x < 32; x++) begin
         for (int y = 0; y < 32; y++) begin
            for (int c = 0; c < 2; c++) begin
               fa = 5'(x); fb = 5'(y); fcin = 1'(c);
               #1;
               e5 = 6'(x + y + c);
               for (int t = 0; t < 3; t++) begin
                  chk("R2 w5", {c5[t], o5[t]}, e5);
                  chk("R3 w5 lsb", o5[t][0], fa[0] ^ fb[0] ^ fcin);
               end
            end
         end
      end

      // Streamed run: latency (R6), ignored carry-in (R4), tied carry-out (R5),
      // wide corners (R8) and random vectors (R1).
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 400; k++) begin
         if (k > 0) @(negedge clk);
         if (k >= 1) begin
            chk("R6 dut one-cycle", {c_d, o_d}, ref64(h1a, h1b, h1c));
            e8 = {1'b0, h1a[7:0]} + {1'b0, h1b[7:0]};
            chk("R4 dut_nc", o_nc, e8[7:0]);
            chk("R5 dut_nc", c_nc, 1'b0);
         end
         if (k >= 2) begin
            e8 = {1'b0, h2a[7:0]} + {1'b0, h2b[7:0]} + {8'd0, h2c};
            chk("R6 dut_p2 two-cycle", {c_p2, o_p2}, e8);
         end
         pick(k, va, vb, vc);
         sa = va; sb = vb; scin = vc;
         #1;
         chk((k < 7) ? "R8 dense 64" : "R1 dense 64", {c_ks, o_ks}, ref64(va, vb, vc));
         chk((k < 7) ? "R8 odd 64" : "R1 odd 64", {c_hc, o_hc}, ref64(va, vb, vc));
         h2a = h1a; h2b = h1b; h2c = h1c;
         h1a = va;  h1b = vb;  h1c = vc;
      end

      finish_run();
   end

endmodule